// File: doc/BRIEF.md
# Sixteen-Pin Register-Controlled I/O Port

This block is one general-purpose I/O port of sixteen pins, configured and driven through a small word-addressed register bus. For each pin, software chooses how it behaves: a plain input, a general output, a pin driven by some other on-chip function, or an analog pin that the digital logic leaves alone. Software also picks whether an output drives in both directions or only pulls low, which pull resistor the pad should enable, and a speed grade. The speed grade is stored for the pad and changes nothing inside the block.

Output levels come from an output data register. A separate write-only set/reset register changes chosen bits of that register in a single bus write, with no read-modify-write sequence. Pin levels come back through a two-stage synchronizer into a read-only input register. When the port clock enable is low, the port behaves as if its clock were stopped. It accepts no register writes and every stored value stays frozen.

Top module: `pin_bank`

## Requirements
- R1: After reset, every register reads 0. No pin has its output enable set and no pull is enabled, so every pin is a floating input.
- R2: The registers are reached at these byte offsets: 0x00 mode, 0x04 output type, 0x08 speed, 0x0C pull, 0x10 input data, 0x14 output data, 0x18 set/reset. Offsets must be word-aligned. Mode, speed and pull hold 32 bits. Output type and output data hold 16 bits and read 0 in bits 31:16. Unmapped offsets read 0.
- R3: Pin n uses mode bits [2n+1:2n]. Code 01 is general output. With output type bit n = 0 (push-pull), padOe[n]=1 and padOut[n] equals output data bit n.
- R4: With output type bit n = 1 (open-drain), a driving pin has padOut[n]=0 and padOe[n] equal to the inverse of its output value, so a high value releases the pin.
- R5: A write to the set/reset register with 1 in bit n (n<16) sets output data bit n. A 1 in bit n+16 clears it. A 0 bit changes nothing.
- R6: If one write to the set/reset register has both bit n and bit n+16 at 1, output data bit n ends up 1.
- R7: The set/reset register reads 0. Writes to the input data register have no effect.
- R8: Mode code 10 (alternate function) takes the output value from altIn[n] in place of output data. The output type rule of R3/R4 still applies.
- R9: Mode codes 00 (input) and 11 (analog) never set padOe[n].
- R10: Pull bits [2n+1:2n] select the pad pull: 01 sets padPullUp[n], 10 sets padPullDn[n], and 00 or 11 enables neither.
- R11: Input data bit n shows pinIn[n] two clock edges after it changes, in every mode except analog (11). An analog pin reads 0.
- R12: While portClkEn is 0, register writes are ignored and all state holds, including the input data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Port clock |
| rstN | input | 1 | Asynchronous active-low reset |
| portClkEn | input | 1 | Port clock enable; 0 freezes the port |
| busAddr | input | 8 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; read data is combinational |
| busRdata | output | 32 | Read data, 0 when busRe is low |
| pinIn | input | 16 | Raw pin levels from the pads |
| altIn | input | 16 | Per-pin output values from alternate on-chip functions |
| padOut | output | 16 | Output level to each pad |
| padOe | output | 16 | Output enable to each pad |
| padPullUp | output | 16 | Pull-up enable to each pad |
| padPullDn | output | 16 | Pull-down enable to each pad |

## Verification
A single set/reset write can ask for both the set and the clear of the same output bit in one cycle. The bench provokes this with a word that carries both the set bit and the clear bit for one pin, while other pins in the same word receive only a set or only a clear. It then reads the output data back, expecting the contested bit to be 1 and the others moved as asked. A second collision happens when a write arrives while portClkEn is low. Here the bench checks that the output data, the mode and the input data all read back unchanged, even though the pins have moved in the meantime.

// File: rtl/pin_bank_pkg.sv
package pin_bank_pkg;

  typedef enum logic [1:0] {
    MD_IN  = 2'b00,
    MD_GPO = 2'b01,
    MD_ALT = 2'b10,
    MD_ANA = 2'b11
  } pinMode_e;

  typedef enum logic [2:0] {
    SEL_MODE,
    SEL_TYPE,
    SEL_SPEED,
    SEL_PULL,
    SEL_IN,
    SEL_OUT,
    SEL_SETCLR,
    SEL_NONE
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrMode;
    logic wrType;
    logic wrSpeed;
    logic wrPull;
    logic wrOut;
    logic wrSetClr;
    logic advance;
  } regStrobe_t;

endpackage

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pin_bank_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              portClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output regStrobe_t        strobe,
  output regSel_e           rdSel
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] wordIdx;
  regSel_e          hitSel;
  logic             wrOk;

  assign wordIdx = busAddr[ADDR_W-1:2];
  assign wrOk    = busWe && portClkEn;

  always_comb begin
    hitSel = SEL_NONE;
    if (busAddr[1:0] == 2'b00) begin
      case (wordIdx)
        IDX_W'(0): hitSel = SEL_MODE;
        IDX_W'(1): hitSel = SEL_TYPE;
        IDX_W'(2): hitSel = SEL_SPEED;
        IDX_W'(3): hitSel = SEL_PULL;
        IDX_W'(4): hitSel = SEL_IN;
        IDX_W'(5): hitSel = SEL_OUT;
        IDX_W'(6): hitSel = SEL_SETCLR;
        default:   hitSel = SEL_NONE;
      endcase
    end
  end

  always_comb begin
    strobe          = '0;
    strobe.advance  = portClkEn;
    strobe.wrMode   = wrOk && (hitSel == SEL_MODE);
    strobe.wrType   = wrOk && (hitSel == SEL_TYPE);
    strobe.wrSpeed  = wrOk && (hitSel == SEL_SPEED);
    strobe.wrPull   = wrOk && (hitSel == SEL_PULL);
    strobe.wrOut    = wrOk && (hitSel == SEL_OUT);
    strobe.wrSetClr = wrOk && (hitSel == SEL_SETCLR);
  end

  assign rdSel = busRe ? hitSel : SEL_NONE;

endmodule

// File: rtl/pin_bank_dp.sv
module pin_bank_dp
  import pin_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strobe,
  input  regSel_e             rdSel,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [PINS-1:0]     pinIn,
  input  logic [PINS-1:0]     altIn,
  output logic [DATA_W-1:0]   rdata,
  output logic [PINS-1:0]     padOut,
  output logic [PINS-1:0]     padOe,
  output logic [PINS-1:0]     padPullUp,
  output logic [PINS-1:0]     padPullDn,
  output logic [2*PINS-1:0]   modeReg,
  output logic [PINS-1:0]     typeReg,
  output logic [PINS-1:0]     outData
);

  localparam int FIELD_W = 2 * PINS;

  logic [FIELD_W-1:0] speedReg;
  logic [FIELD_W-1:0] pullReg;
  logic [PINS-1:0]    syncA;
  logic [PINS-1:0]    syncB;
  logic [PINS-1:0]    anaMask;
  logic [PINS-1:0]    inData;
  logic [PINS-1:0]    setBits;
  logic [PINS-1:0]    clrBits;

  assign setBits = wdata[PINS-1:0];
  assign clrBits = wdata[2*PINS-1:PINS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeReg  <= '0;
      typeReg  <= '0;
      speedReg <= '0;
      pullReg  <= '0;
      outData  <= '0;
    end else begin
      if (strobe.wrMode)  modeReg  <= wdata[FIELD_W-1:0];
      if (strobe.wrType)  typeReg  <= wdata[PINS-1:0];
      if (strobe.wrSpeed) speedReg <= wdata[FIELD_W-1:0];
      if (strobe.wrPull)  pullReg  <= wdata[FIELD_W-1:0];
      if (strobe.wrOut)   outData  <= wdata[PINS-1:0];
      else if (strobe.wrSetClr) outData <= (outData & ~clrBits) | setBits;
    end
  end

  // two-stage synchronizer, frozen while the port clock is off
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else if (strobe.advance) begin
      syncA <= pinIn;
      syncB <= syncA;
    end
  end

  for (genvar g = 0; g < PINS; g++) begin : gPin
    pinMode_e pinMode;
    logic     drives;
    logic     value;
    logic [1:0] pullCode;

    assign pinMode  = pinMode_e'(modeReg[2*g +: 2]);
    assign pullCode = pullReg[2*g +: 2];
    assign drives   = (pinMode == MD_GPO) || (pinMode == MD_ALT);
    assign value    = (pinMode == MD_ALT) ? altIn[g] : outData[g];

    always_comb begin
      if (!drives) begin
        padOut[g] = 1'b0;
        padOe[g]  = 1'b0;
      end else if (typeReg[g]) begin
        padOut[g] = 1'b0;
        padOe[g]  = ~value;
      end else begin
        padOut[g] = value;
        padOe[g]  = 1'b1;
      end
    end

    assign padPullUp[g] = (pullCode == 2'b01);
    assign padPullDn[g] = (pullCode == 2'b10);
    assign anaMask[g]   = (pinMode == MD_ANA);
  end

  assign inData = syncB & ~anaMask;

  always_comb begin
    case (rdSel)
      SEL_MODE:  rdata = DATA_W'(modeReg);
      SEL_TYPE:  rdata = DATA_W'(typeReg);
      SEL_SPEED: rdata = DATA_W'(speedReg);
      SEL_PULL:  rdata = DATA_W'(pullReg);
      SEL_IN:    rdata = DATA_W'(inData);
      SEL_OUT:   rdata = DATA_W'(outData);
      default:   rdata = '0;
    endcase
  end

endmodule

// File: rtl/pin_bank.sv
module pin_bank
  import pin_bank_pkg::*;
#(
  parameter int PINS   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portClkEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busWe,
  input  logic              busRe,
  output logic [31:0]       busRdata,
  input  logic [PINS-1:0]   pinIn,
  input  logic [PINS-1:0]   altIn,
  output logic [PINS-1:0]   padOut,
  output logic [PINS-1:0]   padOe,
  output logic [PINS-1:0]   padPullUp,
  output logic [PINS-1:0]   padPullDn
);

  localparam int DATA_W = 32;

  regStrobe_t         strobe;
  regSel_e            rdSel;
  logic [2*PINS-1:0]  modeReg;
  logic [PINS-1:0]    typeReg;
  logic [PINS-1:0]    outData;

  pin_bank_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .portClkEn (portClkEn),
    .busAddr   (busAddr),
    .busWe     (busWe),
    .busRe     (busRe),
    .strobe    (strobe),
    .rdSel     (rdSel)
  );

  pin_bank_dp #(.PINS(PINS), .DATA_W(DATA_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdSel     (rdSel),
    .wdata     (busWdata),
    .pinIn     (pinIn),
    .altIn     (altIn),
    .rdata     (busRdata),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn),
    .modeReg   (modeReg),
    .typeReg   (typeReg),
    .outData   (outData)
  );

endmodule

// File: rtl/pin_bank_chk.sv
module pin_bank_chk #(
  parameter int PINS   = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              portClkEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic              busWe,
  input logic [PINS-1:0]   padOut,
  input logic [PINS-1:0]   padOe,
  input logic [PINS-1:0]   padPullUp,
  input logic [PINS-1:0]   padPullDn,
  input logic [2*PINS-1:0] modeReg,
  input logic [PINS-1:0]   typeReg,
  input logic [PINS-1:0]   outData
);

  logic [PINS-1:0] quietMask;

  always_comb begin
    for (int i = 0; i < PINS; i++)
      quietMask[i] = (modeReg[2*i +: 2] == 2'b00) || (modeReg[2*i +: 2] == 2'b11);
  end

  // R4
  od_never_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOut & typeReg) == '0);

  // R10
  pull_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDn) == '0);

  // R9
  quiet_no_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & quietMask) == '0);

  // R5
  setclr_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWe && portClkEn && busAddr == ADDR_W'(8'h18)) |=>
      outData == (($past(outData) & ~$past(busWdata[2*PINS-1:PINS])) | $past(busWdata[PINS-1:0])));

  // R12
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !portClkEn |=> ($stable(outData) && $stable(modeReg) && $stable(typeReg)));

endmodule

bind pin_bank pin_bank_chk #(.PINS(PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .portClkEn (portClkEn),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busWe     (busWe),
  .padOut    (padOut),
  .padOe     (padOe),
  .padPullUp (padPullUp),
  .padPullDn (padPullDn),
  .modeReg   (modeReg),
  .typeReg   (typeReg),
  .outData   (outData)
);

// File: tb/pin_bank_bench.sv
`timescale 1ns/1ps
module pin_bank_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        portClkEn = 1'b1;
  logic [7:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic [15:0] pinIn = '0;
  logic [15:0] altIn = '0;
  logic [15:0] padOut, padOe, padPullUp, padPullDn;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  localparam logic [7:0] A_MODE = 8'h00, A_TYPE = 8'h04, A_SPEED = 8'h08,
                         A_PULL = 8'h0C, A_IN = 8'h10, A_OUT = 8'h14, A_SC = 8'h18;

  always #4 clk = ~clk;

  pin_bank u_pin_bank (
    .clk(clk), .rstN(rstN), .portClkEn(portClkEn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe), .busRdata(busRdata),
    .pinIn(pinIn), .altIn(altIn), .padOut(padOut), .padOe(padOe),
    .padPullUp(padPullUp), .padPullDn(padPullDn)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 d = busRdata;
    busRe = 1'b0;
  endtask

  task automatic expectReg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    check(req, v, exp);
  endtask

  task automatic testReset();
    for (int i = 0; i < 8; i++) expectReg("R1 reg", 8'(i * 4), 32'h0);
    check("R1 padOe", {16'h0, padOe}, 32'h0);
    check("R1 pulls", {padPullUp, padPullDn}, 32'h0);
  endtask

  task automatic testRegMap();
    wr(A_MODE, 32'h5555_5555);  expectReg("R2 mode", A_MODE, 32'h5555_5555);
    wr(A_TYPE, 32'hFFFF_00F0);  expectReg("R2 type", A_TYPE, 32'h0000_00F0);
    wr(A_SPEED, 32'hA5A5_1234); expectReg("R2 speed", A_SPEED, 32'hA5A5_1234);
    wr(A_OUT, 32'hDEAD_BEEF);   expectReg("R2 out", A_OUT, 32'h0000_BEEF);
    expectReg("R2 unaligned", 8'h15, 32'h0);
    expectReg("R2 unmapped", 8'h1C, 32'h0);
    wr(A_TYPE, 32'h0);
  endtask

  task automatic testPushPull();
    wr(A_MODE, 32'h5555_5555);
    wr(A_TYPE, 32'h0);
    wr(A_OUT, 32'h0000_00FF);
    @(negedge clk);
    check("R3 padOut", {16'h0, padOut}, 32'h0000_00FF);
    check("R3 padOe", {16'h0, padOe}, 32'h0000_FFFF);
  endtask

  task automatic testOpenDrain();
    wr(A_TYPE, 32'h0000_FFFF);
    wr(A_OUT, 32'h0000_0F0F);
    @(negedge clk);
    check("R4 padOut", {16'h0, padOut}, 32'h0);
    check("R4 padOe", {16'h0, padOe}, 32'h0000_F0F0);
    wr(A_TYPE, 32'h0);
  endtask

  task automatic testSetClr();
    wr(A_OUT, 32'h0000_00F0);
    wr(A_SC, 32'h0030_0001);
    expectReg("R5 set/clear", A_OUT, 32'h0000_00C1);
    wr(A_SC, 32'h0101_0100);
    expectReg("R6 set wins", A_OUT, 32'h0000_01C0);
    wr(A_SC, 32'h0);
    expectReg("R5 zero no effect", A_OUT, 32'h0000_01C0);
    @(negedge clk);
    check("R5 padOut", {16'h0, padOut}, 32'h0000_01C0);
    expectReg("R7 setclr reads 0", A_SC, 32'h0);
  endtask

  task automatic testAlt();
    wr(A_MODE, 32'hAAAA_AAAA);
    wr(A_OUT, 32'h0);
    altIn = 16'h3C3C;
    @(negedge clk);
    check("R8 alt out", {16'h0, padOut}, 32'h0000_3C3C);
    check("R8 alt oe", {16'h0, padOe}, 32'h0000_FFFF);
    wr(A_TYPE, 32'h0000_FFFF);
    @(negedge clk);
    check("R8 alt od out", {16'h0, padOut}, 32'h0);
    check("R8 alt od oe", {16'h0, padOe}, 32'h0000_C3C3);
    wr(A_TYPE, 32'h0);
  endtask

  task automatic testNoDrive();
    wr(A_MODE, 32'hFFFF_0000);
    wr(A_OUT, 32'h0000_FFFF);
    @(negedge clk);
    check("R9 no drive", {16'h0, padOe}, 32'h0);
  endtask

  task automatic testPull();
    wr(A_PULL, 32'h0000_00E4);
    expectReg("R2 pull", A_PULL, 32'h0000_00E4);
    @(negedge clk);
    check("R10 pull up", {16'h0, padPullUp}, 32'h0000_0002);
    check("R10 pull down", {16'h0, padPullDn}, 32'h0000_0004);
  endtask

  task automatic testInput();
    logic [31:0] v;
    wr(A_MODE, 32'h0000_5555);
    @(negedge clk);
    pinIn = 16'hA5A5;
    rd(A_IN, v);
    check("R11 one edge", v, 32'h0);
    rd(A_IN, v);
    check("R11 two edges", v, 32'h0000_A5A5);
    wr(A_MODE, 32'hFF00_5555);
    expectReg("R11 analog zero", A_IN, 32'h0000_05A5);
    wr(A_IN, 32'hFFFF_FFFF);
    expectReg("R7 input readonly", A_IN, 32'h0000_05A5);
  endtask

  task automatic testGate();
    logic [31:0] v;
    wr(A_OUT, 32'h0000_1111);
    @(negedge clk);
    portClkEn = 1'b0;
    wr(A_OUT, 32'h0000_2222);
    wr(A_SC, 32'h1111_0000);
    wr(A_MODE, 32'h0);
    pinIn = 16'h0F0F;
    repeat (3) @(negedge clk);
    expectReg("R12 out held", A_OUT, 32'h0000_1111);
    expectReg("R12 mode held", A_MODE, 32'hFF00_5555);
    expectReg("R12 input held", A_IN, 32'h0000_05A5);
    portClkEn = 1'b1;
    repeat (2) @(negedge clk);
    rd(A_IN, v);
    check("R12 resumes", v, 32'h0000_0F0F);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testRegMap();
    testPushPull();
    testOpenDrain();
    testSetClr();
    testAlt();
    testNoDrive();
    testPull();
    testInput();
    testGate();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule